// File: doc/BRIEF.md
# Eight-Input Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority in which line 0 wins, and raises a single interrupt output toward a processor. Software programs it through a byte-wide register port with one address bit. The controller stays dormant until it receives an ordered series of setup words: a start word, a vector base, an optional cascade word and an optional mode word. After setup, writes to the same port load the mask, issue end-of-interrupt commands, and select which status register the even address reads back.

When the processor acknowledges, the controller records the winning line as in service and returns an 8-bit vector made of the programmed base and the line number. If the request has disappeared by then, it answers with the line-7 vector and marks nothing. A controller can act as a master, whose lines may feed downstream controllers that it names on a 3-bit cascade bus during acknowledge. It can also act as a downstream unit, which answers only when that bus carries its own identifier. A separate trigger register chooses edge or level sensing for each line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the controller is unconfigured. `int_req` stays low, an odd-address read returns 0xFF, and an acknowledge produces no vector.
- R2: An even-address write with bit 4 set starts setup. Bit 1 of that word means no cascade word follows, and bit 0 means a mode word follows. The next odd writes load the vector base (bits 7:3 used), then the cascade word, then the mode word. Starting setup clears the mask, the in-service register and the trigger latches, and sets even-address reads to the request register. Once setup is complete, odd writes load the mask.
- R3: When bit 1 of the mode word is set (auto-EOI), an acknowledge leaves no in-service bit set.
- R4: A 1 in mask bit n blocks line n from being granted. An odd-address read returns the mask.
- R5: `int_req` is high only when some unmasked request exists whose line number is lower than every set in-service bit. The lowest such line wins.
- R6: On a granted acknowledge, `vec_vld` is high in the following cycle with `vec_out` = {base[7:3], n}. In-service bit n is set, and the register gains at most one bit per cycle.
- R7: An even write of 0x60+n clears in-service bit n and no other bit.
- R8: An even write of 0x20 clears the lowest-numbered set in-service bit.
- R9: An even write of 0x0B makes later even reads return the in-service register. An even write of 0x0A returns them to the request register.
- R10: If no eligible request exists at acknowledge, the vector is {base[7:3], 7} and the in-service register is unchanged, even when line 7 is masked.
- R11: Trigger bit n = 1 gives level sensing for line n. Trigger bit n = 0 latches a rising edge, which counts only while the line stays high and is consumed by a grant.
- R12: A master (`role_master`=1) granting line n whose cascade-word bit n is set drives `cas_out`=n with `cas_oe` high during the acknowledge cycle. It then returns no vector but still sets in-service bit n. `cas_oe` is never high outside a master acknowledge.
- R13: A downstream unit (`role_master`=0) answers an acknowledge only when `cas_in` equals bits 2:0 of its cascade word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| role_master | input | 1 | 1 = master, 0 = downstream unit |
| bus_we | input | 1 | Register write strobe |
| bus_a0 | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 8 | Trigger bits, 1 = level |
| irq_in | input | 8 | Request lines |
| int_req | output | 1 | Interrupt to processor |
| ack | input | 1 | One-cycle acknowledge |
| cas_in | input | 3 | Cascade identifier seen by a downstream unit |
| cas_out | output | 3 | Cascade identifier driven by a master |
| cas_oe | output | 1 | Cascade bus drive enable |
| vec_out | output | 8 | Returned vector |
| vec_vld | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The assertions watch the rules that hold in every cycle: the cascade bus is driven only during a master acknowledge, a vector appears only right after an acknowledge, the in-service register never gains two bits at once, auto-EOI keeps it empty, and `int_req` never rises without an unmasked request. The bench scenarios are needed to show the values themselves. These include the vector encoding, the order of the setup words, the effect of each end-of-interrupt form, the spurious line-7 answer, edge consumption, identifier matching, and priority ranking against nested in-service bits over many random mask and request patterns.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       role_master,
  input  logic       bus_we,
  input  logic       bus_a0,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       trig_we,
  input  logic [7:0] trig_wdata,
  input  logic [7:0] irq_in,
  output logic       int_req,
  input  logic       ack,
  input  logic [2:0] cas_in,
  output logic [2:0] cas_out,
  output logic       cas_oe,
  output logic [7:0] vec_out,
  output logic       vec_vld
);
  localparam int LINES = 8;
  localparam int IW = $clog2(LINES);

  typedef enum logic [2:0] {S_OFF, S_BASE, S_CASC, S_MODE, S_RUN} st_t;

  st_t            st;
  logic           skip_casc, want_mode, aeoi_q, rsel_isr;
  logic [7-IW:0]  base_q;
  logic [7:0]     casc_q, mask_q, isr_q, lat_q, prev_q, trig_q;

  function automatic logic [IW:0] lowest(input logic [7:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic [7:0]    irr, cand;
  logic [IW:0]   win, top;
  logic          run, eligible, selected, granted, to_down;
  logic [7:0]    grant_1h, set_1h, clr_1h;

  assign irr      = irq_in & (trig_q | lat_q);
  assign cand     = irr & ~mask_q;
  assign win      = lowest(cand);
  assign top      = lowest(isr_q);
  assign run      = (st == S_RUN);
  assign eligible = win[IW] && (!top[IW] || win[IW-1:0] < top[IW-1:0]);
  assign int_req  = run && eligible;
  assign selected = run && ack && (role_master || cas_in == casc_q[IW-1:0]);
  assign granted  = selected && eligible;
  assign to_down  = role_master && casc_q[win[IW-1:0]];
  assign cas_oe   = granted && to_down;
  assign cas_out  = cas_oe ? win[IW-1:0] : '0;
  assign grant_1h = granted ? (8'b1 << win[IW-1:0]) : 8'h00;
  assign set_1h   = aeoi_q ? 8'h00 : grant_1h;

  logic w_even, w_odd, w_start, w_eoi, w_rsel;
  assign w_even  = bus_we && !bus_a0;
  assign w_odd   = bus_we && bus_a0;
  assign w_start = w_even && bus_wdata[4];
  assign w_eoi   = w_even && run && !bus_wdata[4] && !bus_wdata[3];
  assign w_rsel  = w_even && run && !bus_wdata[4] && bus_wdata[3];

  always_comb begin
    clr_1h = 8'h00;
    if (w_eoi) begin
      if (bus_wdata[7:5] == 3'b011) clr_1h = 8'b1 << bus_wdata[IW-1:0];
      else if (bus_wdata[7:5] == 3'b001 && top[IW]) clr_1h = 8'b1 << top[IW-1:0];
    end
  end

  assign bus_rdata = bus_a0 ? mask_q : (rsel_isr ? isr_q : irr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      skip_casc <= 1'b0;
      want_mode <= 1'b0;
      aeoi_q    <= 1'b0;
      rsel_isr  <= 1'b0;
      base_q    <= '0;
      casc_q    <= 8'h00;
      mask_q    <= 8'hFF;
    end else if (w_start) begin
      st        <= S_BASE;
      skip_casc <= bus_wdata[1];
      want_mode <= bus_wdata[0];
      aeoi_q    <= 1'b0;
      rsel_isr  <= 1'b0;
      casc_q    <= 8'h00;
      mask_q    <= 8'h00;
    end else begin
      if (w_rsel && bus_wdata[1]) rsel_isr <= bus_wdata[0];
      if (w_odd) begin
        case (st)
          S_BASE: begin
            base_q <= bus_wdata[7:IW];
            st     <= !skip_casc ? S_CASC : (want_mode ? S_MODE : S_RUN);
          end
          S_CASC: begin
            casc_q <= bus_wdata;
            st     <= want_mode ? S_MODE : S_RUN;
          end
          S_MODE: begin
            aeoi_q <= bus_wdata[1];
            st     <= S_RUN;
          end
          S_RUN:   mask_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= 8'h00;
      lat_q  <= 8'h00;
      prev_q <= 8'h00;
      trig_q <= 8'h00;
    end else begin
      prev_q <= irq_in;
      if (trig_we) trig_q <= trig_wdata;
      if (w_start) begin
        isr_q <= 8'h00;
        lat_q <= 8'h00;
      end else begin
        isr_q <= (isr_q | set_1h) & ~clr_1h;
        lat_q <= (lat_q | (irq_in & ~prev_q)) & irq_in & ~grant_1h;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out <= 8'h00;
      vec_vld <= 1'b0;
    end else begin
      vec_vld <= selected && !cas_oe;
      if (selected)
        vec_out <= {base_q, eligible ? win[IW-1:0] : IW'(LINES - 1)};
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       role_master,
  input logic       ack,
  input logic       int_req,
  input logic       cas_oe,
  input logic       vec_vld,
  input logic       aeoi_q,
  input logic [7:0] isr_q,
  input logic [7:0] mask_q,
  input logic [7:0] irr
);
  AST_CAS_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> (role_master && ack)); // R12

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(ack)); // R6

  AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1); // R6

  AST_AEOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_q |-> (isr_q == 8'h00)); // R3

  AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~mask_q) != 8'h00)); // R5
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .role_master(role_master), .ack(ack),
  .int_req(int_req), .cas_oe(cas_oe), .vec_vld(vec_vld), .aeoi_q(aeoi_q),
  .isr_q(isr_q), .mask_q(mask_q), .irr(irr)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       role_master = 1'b1, bus_we = 1'b0, bus_a0 = 1'b0, trig_we = 1'b0, ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00, trig_wdata = 8'h00, irq_in = 8'h00;
  logic [2:0] cas_in = 3'd0;
  logic [7:0] bus_rdata, vec_out;
  logic [2:0] cas_out;
  logic       int_req, cas_oe, vec_vld;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_a0 = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_a0 = a; #1 d = bus_rdata;
  endtask

  task automatic set_trig(input logic [7:0] t);
    @(negedge clk); trig_we = 1'b1; trig_wdata = t;
    @(negedge clk); trig_we = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] cid, output logic oe, output logic [2:0] co,
                        output logic vv, output logic [7:0] v);
    @(negedge clk); cas_in = cid; ack = 1'b1;
    #1 oe = cas_oe; co = cas_out;
    @(negedge clk); ack = 1'b0;
    #1 vv = vec_vld; v = vec_out;
  endtask

  function automatic int pick(input logic [7:0] req, input logic [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return -1;
      if (req[i]) return i;
    end
    return -1;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v, isr_m, msk, req;
    logic oe, vv;
    logic [2:0] co;
    int w;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and ignored acknowledge
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    rd(1'b1, r); check("R1 mask", r, 8'hFF);
    set_trig(8'hFF); irq_in = 8'h08;
    do_ack(3'd0, oe, co, vv, v);
    check("R1 ack ignored", {7'd0, vv}, 8'h00);
    check("R1 int_req with request", {7'd0, int_req}, 8'h00);
    irq_in = 8'h00;

    // R2: full setup sequence, master with downstream on line 2
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, r); check("R2 mask cleared", r, 8'h00);

    // R5 R6 R9: level requests, grant and status reads
    irq_in = 8'h28; @(negedge clk);
    check("R5 int_req", {7'd0, int_req}, 8'h01);
    do_ack(3'd0, oe, co, vv, v);
    check("R6 vec_vld", {7'd0, vv}, 8'h01);
    check("R6 vector", v, 8'h23);
    rd(1'b0, r); check("R9 irr default", r, 8'h28);
    wr(1'b0, 8'h0B); rd(1'b0, r); check("R9 isr select", r, 8'h08);
    check("R5 blocked by in-service", {7'd0, int_req}, 8'h00);
    irq_in = 8'h22; @(negedge clk);
    check("R5 higher line passes", {7'd0, int_req}, 8'h01);
    do_ack(3'd0, oe, co, vv, v);
    check("R6 nested vector", v, 8'h21);
    rd(1'b0, r); check("R6 nested isr", r, 8'h0A);
    wr(1'b0, 8'h20); rd(1'b0, r); check("R8 nonspecific", r, 8'h08);
    wr(1'b0, 8'h65); rd(1'b0, r); check("R7 other bit untouched", r, 8'h08);
    wr(1'b0, 8'h63); rd(1'b0, r); check("R7 specific", r, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, r); check("R9 irr reselect", r, 8'h22);

    // R4: mask
    wr(1'b1, 8'h02); rd(1'b1, r); check("R4 mask read", r, 8'h02);
    do_ack(3'd0, oe, co, vv, v);
    check("R4 masked line skipped", v, 8'h25);
    wr(1'b0, 8'h65);

    // R10: spurious with line 7 masked
    wr(1'b1, 8'h80); wr(1'b0, 8'h0B);
    irq_in = 8'h01; @(negedge clk);
    check("R10 pending", {7'd0, int_req}, 8'h01);
    irq_in = 8'h00;
    do_ack(3'd0, oe, co, vv, v);
    check("R10 vector", v, 8'h27);
    rd(1'b0, r); check("R10 isr unchanged", r, 8'h00);

    // R12: master forwards line 2 to downstream
    wr(1'b1, 8'h00); irq_in = 8'h04;
    do_ack(3'd0, oe, co, vv, v);
    check("R12 cas_oe", {7'd0, oe}, 8'h01);
    check("R12 cas_out", {5'd0, co}, 8'h02);
    check("R12 no vector", {7'd0, vv}, 8'h00);
    rd(1'b0, r); check("R12 isr", r, 8'h04);
    wr(1'b0, 8'h62); irq_in = 8'h00;

    // R11: edge trigger
    set_trig(8'h00);
    irq_in = 8'h10; @(negedge clk); @(negedge clk);
    check("R11 edge seen", {7'd0, int_req}, 8'h01);
    do_ack(3'd0, oe, co, vv, v);
    check("R11 edge vector", v, 8'h24);
    wr(1'b0, 8'h64); @(negedge clk);
    check("R11 edge consumed", {7'd0, int_req}, 8'h00);
    irq_in = 8'h00; @(negedge clk); irq_in = 8'h10; @(negedge clk); @(negedge clk);
    check("R11 new edge", {7'd0, int_req}, 8'h01);
    irq_in = 8'h00; @(negedge clk);
    check("R11 edge needs line high", {7'd0, int_req}, 8'h00);

    // R3: auto-EOI
    set_trig(8'hFF);
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h03);
    irq_in = 8'h08;
    rd(1'b0, r); check("R2 read select reset to irr", r, 8'h08);
    do_ack(3'd0, oe, co, vv, v);
    check("R3 vector", v, 8'h43);
    wr(1'b0, 8'h0B); rd(1'b0, r); check("R3 isr empty", r, 8'h00);
    irq_in = 8'h00;

    // R2: no cascade word, no mode word
    wr(1'b0, 8'h12); wr(1'b1, 8'h80); wr(1'b1, 8'h3C);
    rd(1'b1, r); check("R2 short sequence mask", r, 8'h3C);

    // R13: downstream unit
    role_master = 1'b0;
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    irq_in = 8'h02;
    do_ack(3'd3, oe, co, vv, v);
    check("R13 wrong id silent", {7'd0, vv}, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, r); check("R13 wrong id isr", r, 8'h00);
    do_ack(3'd2, oe, co, vv, v);
    check("R13 match vector", v, 8'h29);
    check("R12 downstream never drives", {7'd0, oe}, 8'h00);
    irq_in = 8'h00; role_master = 1'b1;

    // R5 R6: random masks and requests against a model
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h01);
    wr(1'b0, 8'h0B);
    isr_m = 8'h00;
    for (int k = 0; k < 80; k++) begin
      msk = 8'($urandom); req = 8'($urandom);
      wr(1'b1, msk); irq_in = req; @(negedge clk);
      w = pick(req & ~msk, isr_m);
      check("R5 random int_req", {7'd0, int_req}, (w >= 0) ? 8'h01 : 8'h00);
      if ($urandom % 2 == 0) begin
        do_ack(3'd0, oe, co, vv, v);
        check("R6 random vector", v, 8'h20 | ((w >= 0) ? 8'(w) : 8'h07));
        if (w >= 0) isr_m[w] = 1'b1;
      end
      if ($urandom % 3 == 0) begin
        int n = int'($urandom % 8);
        wr(1'b0, 8'h60 + 8'(n)); isr_m[n] = 1'b0;
      end
      rd(1'b0, r); check("R6 random isr", r, isr_m);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule